// File: doc/BRIEF.md
# Flash Program/Erase Suspend Sequencer

This block is the command interpreter and operation sequencer for a parallel NOR flash array. Commands arrive one byte at a time, each with an address, on a synchronous write strobe. The block runs block erase and byte write operations. It can suspend and resume either one. It also allows one byte write to run while an erase is held in suspend. It reports progress through an 8-bit status word and an active-low ready/busy output.

The array is not stored. Each operation is modelled by a countdown timer whose length is a parameter, and a suspend request takes a fixed, parameterized number of cycles to take effect. While a byte write is suspended, the host may switch to array reads. The block flags any read address that hits the location whose write is paused, so the read path can refuse it.

Status word layout, used throughout: bit 7 is ready (1 = idle or suspended), bit 6 is erase-suspended, bits 5 and 4 together form the sequence-error flag, bit 2 is write-suspended, and bits 3, 1 and 0 always read 0. Command bytes: 0x20 erase setup, 0xD0 confirm/resume, 0x40 write setup, 0xB0 suspend, 0x70 read status, 0xFF read array, 0x50 clear status.

Top module: `flash_susp_ctrl`

## Requirements
- R1: After reset the status word is 0x80, busy_n is 1 and reads select array data (rd_status = 0).
- R2: Writing 0x20 and then 0xD0 starts an erase. Status bit 7 and busy_n stay 0 for exactly ERASE_CYC cycles, then return to 1. The confirm switches reads to status.
- R3: Writing 0x40 and then any data byte with an address starts a byte write. The write is busy for exactly WRITE_CYC cycles, and that address is captured as the write target.
- R4: 0xB0 during a running operation makes it ready SUSP_LAT cycles later, with bit 6 set for an erase or bit 2 set for a write. If the operation's timer ends first, it completes normally. 0xB0 when no operation runs changes nothing.
- R5: While an erase is suspended, 0x70, 0xFF, 0xD0, 0x40 and 0xB0 are legal, and 0xB0 has no effect. Any other byte is ignored and sets status bits 5 and 4.
- R6: A byte write started while an erase is suspended shows bit 7 = 0, busy_n = 0 and bit 6 still 1. When it finishes, the status returns to erase-suspended and ready (bits 7 and 6 set).
- R7: 0xD0 written during such a nested byte write is held. The erase resumes only when the write completes: bit 6 clears on that cycle and the erase continues busy.
- R8: While a write is suspended, only 0xFF, 0x70 and 0xD0 are legal. Any other byte is ignored and sets bits 5 and 4. 0xD0 resumes the write, clearing bits 2 and 7.
- R9: Each resume (erase or write) clears its suspend bit and bit 7, drives busy_n low and switches reads to status.
- R10: While a write is suspended and reads select array data, rd_blocked is 1 exactly when rd_addr equals the suspended write's address.
- R11: When idle, 0x70 selects status reads, 0xFF selects array reads, 0x50 clears bits 5 and 4, and other bytes are ignored. An erase setup followed by any byte other than 0xD0 aborts and sets bits 5 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Command/data write strobe, one cycle per byte |
| wr_cmd | input | 8 | Command or data byte |
| wr_addr | input | AW | Address accompanying the byte |
| rd_addr | input | AW | Address of the current array read |
| status | output | 8 | Status word |
| busy_n | output | 1 | Ready/busy, low while an operation runs |
| rd_status | output | 1 | 1 when reads return the status word |
| rd_blocked | output | 1 | Array read hits the suspended write location |

## Verification
The bench builds the block with ERASE_CYC = 60, WRITE_CYC = 12, SUSP_LAT = 4 and AW = 20. These short timers make exact busy durations cheap to count. They also let a suspend be timed to arrive two cycles before a write ends, so the write wins the race. The erase is long enough to be suspended twice, to carry a nested write inside its suspend and to take a deferred resume, all while cycles of it remain.

// File: rtl/flash_seq_pkg.sv
// Shared types for the flash suspend sequencer.
// Assumes: commands are single bytes; one operation context at a time plus
// one nested byte write inside a suspended erase.
package flash_seq_pkg;

    localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
    localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
    localparam logic [7:0] CMD_WRITE_SETUP = 8'h40;
    localparam logic [7:0] CMD_SUSPEND     = 8'hB0;
    localparam logic [7:0] CMD_RD_STATUS   = 8'h70;
    localparam logic [7:0] CMD_RD_ARRAY    = 8'hFF;
    localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ESETUP,
        S_WSETUP,
        S_ERUN,
        S_EPEND,
        S_ESUSP,
        S_WRUN,
        S_WPEND,
        S_WSUSP
    } seq_state_t;

    typedef struct packed {
        logic erase_setup;
        logic confirm;
        logic write_setup;
        logic suspend;
        logic rd_status;
        logic rd_array;
        logic clr_status;
    } cmd_kind_t;

endpackage

// File: rtl/fsq_cmd_decode.sv
// Command byte classifier.
// Turns a strobed byte into one flag per known command; all flags are 0
// when the strobe is low or the byte is not a known command.
module fsq_cmd_decode
    import flash_seq_pkg::*;
(
    input  logic      wr_en,
    input  logic [7:0] wr_cmd,
    output cmd_kind_t kind
);

    // Compare the byte against each command code, gated by the strobe.
    always_comb begin
        kind.erase_setup = wr_en && (wr_cmd == CMD_ERASE_SETUP);
        kind.confirm     = wr_en && (wr_cmd == CMD_CONFIRM);
        kind.write_setup = wr_en && (wr_cmd == CMD_WRITE_SETUP);
        kind.suspend     = wr_en && (wr_cmd == CMD_SUSPEND);
        kind.rd_status   = wr_en && (wr_cmd == CMD_RD_STATUS);
        kind.rd_array    = wr_en && (wr_cmd == CMD_RD_ARRAY);
        kind.clr_status  = wr_en && (wr_cmd == CMD_CLR_STATUS);
    end

endmodule

// File: rtl/fsq_timer.sv
// Loadable countdown timer.
// load sets the count to LEN; while run is high the count decrements and
// expire pulses in the run cycle where the count is 1. The count is held
// while run is low, which is how a suspended operation keeps its remainder.
module fsq_timer #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expire
);

    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt;

    // Count register: load has priority, otherwise decrement while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= CW'(LEN);
        else if (run && cnt != '0)
            cnt <= cnt - CW'(1);
    end

    // Expiry flag for the last running cycle.
    assign expire = run && (cnt == CW'(1));

endmodule

// File: rtl/fsq_ctrl.sv
// Sequencer state machine for erase, byte write, suspend and resume.
// Assumes timer expiry inputs come from fsq_timer instances driven by the
// run/load outputs here. Holds the erase-suspended context while a nested
// byte write runs, and defers an erase resume until that write completes.
module fsq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  cmd_kind_t     kind,
    input  logic [AW-1:0] wr_addr,
    input  logic [AW-1:0] rd_addr,
    input  logic          e_done,
    input  logic          w_done,
    input  logic          l_done,
    output logic          e_load,
    output logic          w_load,
    output logic          l_load,
    output logic          e_run,
    output logic          w_run,
    output logic          l_run,
    output seq_state_t    st,
    output logic [7:0]    status,
    output logic          rd_status,
    output logic          rd_blocked
);

    seq_state_t    st_n;
    logic          esusp, esusp_n;
    logic          rpend, rpend_n;
    logic          rdst_n;
    logic          err, err_n;
    logic          wa_load;
    logic          defer;
    logic [AW-1:0] waddr;

    // Next-state and command legality per state.
    always_comb begin
        st_n    = st;
        esusp_n = esusp;
        rpend_n = rpend;
        rdst_n  = rd_status;
        err_n   = err;
        e_load  = 1'b0;
        w_load  = 1'b0;
        l_load  = 1'b0;
        wa_load = 1'b0;
        defer   = rpend || (esusp && kind.confirm);
        case (st)
            S_IDLE: begin
                if (kind.erase_setup)      st_n = S_ESETUP;
                else if (kind.write_setup) st_n = S_WSETUP;
                else if (kind.rd_status)   rdst_n = 1'b1;
                else if (kind.rd_array)    rdst_n = 1'b0;
                else if (kind.clr_status)  err_n = 1'b0;
            end
            S_ESETUP: begin
                if (wr_en) begin
                    rdst_n = 1'b1;
                    if (kind.confirm) begin
                        st_n   = S_ERUN;
                        e_load = 1'b1;
                    end else begin
                        st_n  = S_IDLE;
                        err_n = 1'b1;
                    end
                end
            end
            S_WSETUP: begin
                if (wr_en) begin
                    st_n    = S_WRUN;
                    w_load  = 1'b1;
                    wa_load = 1'b1;
                    rdst_n  = 1'b1;
                end
            end
            S_ERUN, S_EPEND: begin
                if (kind.rd_status) rdst_n = 1'b1;
                if (e_done) begin
                    st_n = S_IDLE;
                end else if (st == S_EPEND && l_done) begin
                    st_n    = S_ESUSP;
                    esusp_n = 1'b1;
                end else if (st == S_ERUN && kind.suspend) begin
                    st_n   = S_EPEND;
                    l_load = 1'b1;
                end
            end
            S_ESUSP: begin
                if (kind.rd_status)        rdst_n = 1'b1;
                else if (kind.rd_array)    rdst_n = 1'b0;
                else if (kind.confirm) begin
                    st_n    = S_ERUN;
                    esusp_n = 1'b0;
                    rdst_n  = 1'b1;
                end
                else if (kind.write_setup) st_n = S_WSETUP;
                else if (kind.suspend)     st_n = S_ESUSP;
                else if (wr_en)            err_n = 1'b1;
            end
            S_WRUN, S_WPEND: begin
                if (kind.rd_status) rdst_n = 1'b1;
                if (w_done) begin
                    if (!esusp) begin
                        st_n = S_IDLE;
                    end else if (defer) begin
                        st_n    = S_ERUN;
                        esusp_n = 1'b0;
                        rpend_n = 1'b0;
                    end else begin
                        st_n = S_ESUSP;
                    end
                end else begin
                    if (esusp && kind.confirm) rpend_n = 1'b1;
                    if (st == S_WPEND && l_done) begin
                        st_n = S_WSUSP;
                    end else if (st == S_WRUN && kind.suspend) begin
                        st_n   = S_WPEND;
                        l_load = 1'b1;
                    end
                end
            end
            S_WSUSP: begin
                if (kind.rd_status)     rdst_n = 1'b1;
                else if (kind.rd_array) rdst_n = 1'b0;
                else if (kind.confirm) begin
                    st_n   = S_WRUN;
                    rdst_n = 1'b1;
                end
                else if (wr_en)         err_n = 1'b1;
            end
            default: st_n = S_IDLE;
        endcase
    end

    // State, context flags and read mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            esusp     <= 1'b0;
            rpend     <= 1'b0;
            rd_status <= 1'b0;
            err       <= 1'b0;
        end else begin
            st        <= st_n;
            esusp     <= esusp_n;
            rpend     <= rpend_n;
            rd_status <= rdst_n;
            err       <= err_n;
        end
    end

    // Captured target address of the current byte write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            waddr <= '0;
        else if (wa_load)
            waddr <= wr_addr;
    end

    // Timer enables follow the running and pending states.
    assign e_run = (st == S_ERUN)  || (st == S_EPEND);
    assign w_run = (st == S_WRUN)  || (st == S_WPEND);
    assign l_run = (st == S_EPEND) || (st == S_WPEND);

    // Status word assembly from state and flags.
    assign status = {!(e_run || w_run), esusp, err, err, 1'b0,
                     (st == S_WSUSP), 2'b00};

    // Guard for array reads that hit the paused write location.
    assign rd_blocked = (st == S_WSUSP) && !rd_status && (rd_addr == waddr);

endmodule

// File: rtl/flash_susp_ctrl.sv
// Top of the flash program/erase suspend sequencer.
// Wires the command decoder, the sequencer and three timers (erase length,
// write length, suspend latency). Assumes wr_en is a one-cycle strobe per
// byte, synchronous to clk.
module flash_susp_ctrl
    import flash_seq_pkg::*;
#(
    parameter int AW        = 20,
    parameter int ERASE_CYC = 2000,
    parameter int WRITE_CYC = 40,
    parameter int SUSP_LAT  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_cmd,
    input  logic [AW-1:0] wr_addr,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    status,
    output logic          busy_n,
    output logic          rd_status,
    output logic          rd_blocked
);

    cmd_kind_t  kind;
    seq_state_t seq_state;
    logic e_load, w_load, l_load;
    logic e_run, w_run, l_run;
    logic e_done, w_done, l_done;

    fsq_cmd_decode u_dec (
        .wr_en  (wr_en),
        .wr_cmd (wr_cmd),
        .kind   (kind)
    );

    fsq_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .kind       (kind),
        .wr_addr    (wr_addr),
        .rd_addr    (rd_addr),
        .e_done     (e_done),
        .w_done     (w_done),
        .l_done     (l_done),
        .e_load     (e_load),
        .w_load     (w_load),
        .l_load     (l_load),
        .e_run      (e_run),
        .w_run      (w_run),
        .l_run      (l_run),
        .st         (seq_state),
        .status     (status),
        .rd_status  (rd_status),
        .rd_blocked (rd_blocked)
    );

    fsq_timer #(.LEN(ERASE_CYC)) u_erase_tmr (
        .clk(clk), .rst_n(rst_n), .load(e_load), .run(e_run), .expire(e_done)
    );

    fsq_timer #(.LEN(WRITE_CYC)) u_write_tmr (
        .clk(clk), .rst_n(rst_n), .load(w_load), .run(w_run), .expire(w_done)
    );

    fsq_timer #(.LEN(SUSP_LAT)) u_lat_tmr (
        .clk(clk), .rst_n(rst_n), .load(l_load), .run(l_run), .expire(l_done)
    );

    // Ready/busy pin mirrors the ready bit of the status word.
    assign busy_n = status[7];

endmodule

// File: rtl/flash_susp_ctrl_chk.sv
// Protocol checker for flash_susp_ctrl, attached by bind.
// Observes the command strobe, the sequencer state and the outputs.
module flash_susp_ctrl_chk
    import flash_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_cmd,
    input seq_state_t st,
    input logic [7:0] status,
    input logic       rd_status,
    input logic       rd_blocked
);

    logic esusp_legal;
    logic wsusp_legal;

    assign esusp_legal = (wr_cmd == CMD_RD_STATUS) || (wr_cmd == CMD_RD_ARRAY) ||
                         (wr_cmd == CMD_CONFIRM)   || (wr_cmd == CMD_WRITE_SETUP) ||
                         (wr_cmd == CMD_SUSPEND);
    assign wsusp_legal = (wr_cmd == CMD_RD_STATUS) || (wr_cmd == CMD_RD_ARRAY) ||
                         (wr_cmd == CMD_CONFIRM);

    // R4
    susp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[2]) |-> status[7]);

    // R4
    idle_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_cmd == CMD_SUSPEND && st == S_IDLE) |=> $stable(status));

    // R5
    esusp_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && st == S_ESUSP && !esusp_legal) |=> (status[5] && status[4] && status[6]));

    // R6
    nested_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && st == S_WSETUP && status[6]) |=> (!status[7] && status[6]));

    // R7
    defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_cmd == CMD_CONFIRM && st == S_WRUN && status[6])
        |=> (status[6] || st == S_ERUN));

    // R8
    wsusp_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && st == S_WSUSP && !wsusp_legal) |=> (status[5] && status[4] && status[2]));

    // R9
    wresume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_cmd == CMD_CONFIRM && st == S_WSUSP)
        |=> (!status[2] && !status[7] && rd_status));

    // R10
    guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_blocked |-> (status[2] && !rd_status));

endmodule

bind flash_susp_ctrl flash_susp_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_cmd     (wr_cmd),
    .st         (seq_state),
    .status     (status),
    .rd_status  (rd_status),
    .rd_blocked (rd_blocked)
);

// File: tb/flash_susp_ctrl_tb.sv
module flash_susp_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW  = 20;
    localparam int EC  = 60;
    localparam int WC  = 12;
    localparam int SL  = 4;
    localparam int NV  = 8;

    // Idle-context vectors: command, expected status, expected read mode.
    localparam logic [7:0] V_CMD [NV] = '{8'h70, 8'hFF, 8'hB0, 8'h20, 8'h40, 8'hFF, 8'h50, 8'h33};
    localparam logic [7:0] V_ST  [NV] = '{8'h80, 8'h80, 8'h80, 8'h80, 8'hB0, 8'hB0, 8'h80, 8'h80};
    localparam logic       V_RDS [NV] = '{1'b1,  1'b0,  1'b0,  1'b0,  1'b1,  1'b0,  1'b0,  1'b0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_cmd = '0;
    logic [AW-1:0] wr_addr = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    status;
    logic          busy_n, rd_status, rd_blocked;
    int checks = 0;
    int fails = 0;
    int n;
    bit done = 1'b0;

    flash_susp_ctrl #(.AW(AW), .ERASE_CYC(EC), .WRITE_CYC(WC), .SUSP_LAT(SL)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_addr(wr_addr),
        .rd_addr(rd_addr), .status(status), .busy_n(busy_n), .rd_status(rd_status),
        .rd_blocked(rd_blocked)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [7:0] b, input logic [AW-1:0] a);
        wr_en = 1'b1; wr_cmd = b; wr_addr = a;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_ready(output int cnt);
        cnt = 0;
        while (!busy_n && cnt < 5000) begin
            @(negedge clk);
            cnt++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 status", status, 8'h80);
        chk("R1 busy_n", busy_n, 1);
        chk("R1 rd_status", rd_status, 0);

        // R11 / R4 idle-context table
        for (int i = 0; i < NV; i++) begin
            cmd(V_CMD[i], '0);
            chk($sformatf("R11 table[%0d] status", i), status, V_ST[i]);
            chk($sformatf("R11 table[%0d] rd_status", i), rd_status, V_RDS[i]);
        end

        // R2 full erase
        cmd(8'h20, 20'h100); cmd(8'hD0, 20'h100);
        chk("R2 busy status", status, 8'h00);
        chk("R2 busy_n", busy_n, 0);
        chk("R2 rd_status", rd_status, 1);
        wait_ready(n);
        chk("R2 erase cycles", n, EC);
        chk("R2 done status", status, 8'h80);

        // R3 full byte write
        cmd(8'h40, '0); cmd(8'h5A, 20'h00100);
        chk("R3 busy status", status, 8'h00);
        wait_ready(n);
        chk("R3 write cycles", n, WC);

        // R4 write suspend, R10 guard, R8 illegal, R9 resume
        cmd(8'h40, '0); cmd(8'hA5, 20'h00123);
        repeat (3) @(negedge clk);
        cmd(8'hB0, '0);
        chk("R4 latency busy", status, 8'h00);
        wait_ready(n);
        chk("R4 write suspend latency", n, SL);
        chk("R4 write suspended status", status, 8'h84);
        cmd(8'hFF, '0);
        rd_addr = 20'h00123; #1;
        chk("R10 blocked hit", rd_blocked, 1);
        rd_addr = 20'h00124; #1;
        chk("R10 blocked miss", rd_blocked, 0);
        cmd(8'h20, '0);
        chk("R8 illegal in write suspend", status, 8'hB4);
        cmd(8'hD0, '0);
        chk("R9 write resume status", status, 8'h30);
        chk("R9 write resume rd_status", rd_status, 1);
        wait_ready(n);
        chk("R8 resumed write done", status, 8'hB0);
        cmd(8'h50, '0);
        chk("R11 clear", status, 8'h80);

        // R4 late suspend loses the race
        cmd(8'h40, '0); cmd(8'h11, 20'h00200);
        repeat (WC - 3) @(negedge clk);
        cmd(8'hB0, '0);
        repeat (SL + 2) @(negedge clk);
        chk("R4 late suspend no effect", status, 8'h80);

        // R4 / R5 erase suspend
        cmd(8'h20, '0); cmd(8'hD0, '0);
        repeat (5) @(negedge clk);
        cmd(8'hB0, '0);
        wait_ready(n);
        chk("R4 erase suspend latency", n, SL);
        chk("R4 erase suspended status", status, 8'hC0);
        cmd(8'h70, '0);
        chk("R5 rd status legal", status, 8'hC0);
        cmd(8'hFF, '0);
        chk("R5 rd array mode", rd_status, 0);
        cmd(8'hB0, '0);
        chk("R5 suspend no effect", status, 8'hC0);
        cmd(8'hD0, '0);
        chk("R9 erase resume status", status, 8'h00);
        chk("R9 erase resume rd_status", rd_status, 1);
        repeat (3) @(negedge clk);
        cmd(8'hB0, '0);
        wait_ready(n);
        cmd(8'h50, '0);
        chk("R5 illegal in erase suspend", status, 8'hF0);

        // R6 / R7 nested write with deferred erase resume
        cmd(8'h40, '0); cmd(8'h77, 20'h00300);
        chk("R6 nested status", status, 8'h70);
        chk("R6 nested busy_n", busy_n, 0);
        cmd(8'hD0, '0);
        chk("R7 resume held", status, 8'h70);
        n = 0;
        while (status[6] && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk("R7 deferred resume timing", n, WC - 1);
        chk("R7 erase continues", status, 8'h30);
        wait_ready(n);
        chk("R7 erase finished", status, 8'hB0);
        cmd(8'h50, '0);

        // R6 nested write returns to erase suspend
        cmd(8'h20, '0); cmd(8'hD0, '0);
        repeat (2) @(negedge clk);
        cmd(8'hB0, '0);
        wait_ready(n);
        cmd(8'h40, '0); cmd(8'h99, 20'h00400);
        wait_ready(n);
        chk("R6 nested write cycles", n, WC);
        chk("R6 back to erase suspend", status, 8'hC0);
        cmd(8'hD0, '0);
        wait_ready(n);
        chk("R2 erase after nesting", status, 8'h80);

        // R1 reset during busy
        cmd(8'h20, '0); cmd(8'hD0, '0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset mid erase", status, 8'h80);
        chk("R1 reset rd_status", rd_status, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule